// File: doc/BRIEF.md
# Buffered Down-Counting PWM Timer

This block holds five timer channels that each count down from a value held in a count buffer. Channels 0 to 3 also drive a pulse-width output. A compare buffer sets the point in the count where that output switches. Channel 4 only counts. Every channel emits a one-cycle expiry pulse when its counter leaves zero. The tick that drives a channel comes from one of two shared 8-bit prescalers. Channels 0 and 1 use the first prescaler and channels 2 to 4 use the second. Each channel then has its own power-of-two divider.

Software sets the block up through a flat register port. Writes are synchronous and reads are combinational. Buffer registers never touch a running counter directly. Their contents move into the active counter and compare registers in only two cases: while the channel's load bit is held, or when the counter wraps with reload enabled. This lets software stage a new period or duty while the current period finishes unchanged.

Each channel runs a four-state controller:
- `CH_IDLE`: nothing is armed and the output sits at its inactive level.
- `CH_LOAD`: the load bit is held, and the buffers are copied every cycle.
- `CH_HOLD`: the channel is armed but halted.
- `CH_RUN`: the channel is counting.

Its transitions are:
- Any state goes to `CH_LOAD` while the load bit is set.
- `CH_LOAD` goes to `CH_RUN` or `CH_HOLD` once the load bit clears, depending on the run bit.
- `CH_HOLD` goes to `CH_RUN` when the run bit is set.
- `CH_RUN` goes to `CH_HOLD` when the run bit clears.
- `CH_RUN` goes to `CH_IDLE` when the counter sits at zero on a tick with reload off.
- A zero tick with reload on stays in `CH_RUN` and reloads the counter.

Top module: `pwm_timer`

Register map (word addresses):
| Addr | Contents |
|---|---|
| 0 | prescaler A in bits 7:0, prescaler B in bits 15:8 |
| 1 | divider fields, 4 bits per channel at bit 4*ch |
| 2 | control, 4 bits per channel at bit 4*ch |
| 3+ch | count buffer of channel ch (0..4), 16 bits |
| 8+ch | compare buffer of channel ch (0..3), 16 bits |

Each control nibble holds four bits:
| Bit | Meaning |
|---|---|
| 0 | run |
| 1 | load |
| 2 | reload |
| 3 | invert |

## Requirements
- R1: After reset, all outputs are 0 and every register reads 0.
- R2: Each register listed above reads back what was written, masked to its width (count and compare buffers keep 16 bits). An unmapped address reads 0.
- R3: One tick of a channel lasts (P+1)·2^(S+1) clock cycles. P is the prescaler of its group (A for channels 0–1, B for channels 2–4). S is the low two bits of its divider field, where 0,1,2,3 select /2,/4,/8,/16. The upper two bits of the field are ignored.
- R4: With reload on, a channel with count value N expires once every N+1 ticks.
- R5: With compare value C below N, the output is active from the decrement that lands the counter on C until the reload. That is (C+1) ticks per period, so C=0 gives one tick.
- R6: Compare is tested only after a decrement, so C equal to N never makes the output active.
- R7: The invert bit flips the output polarity, including the inactive level.
- R8: While the load bit is set, the buffers are copied into the counter and no counting or expiry happens, even with run set.
- R9: Writing a buffer while the channel runs leaves the current period unchanged. The new value applies from the next reload.
- R10: With reload off, the channel expires once and stops with its output at the inactive level.
- R11: Clearing run freezes the counter and output. Setting it again resumes from the frozen count.
- R12: Channel 4 has no output pin but counts and expires like the others, ticking from prescaler B.
- R13: The expiry pulse lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 4 | register write address |
| wr_data | input | 32 | register write data |
| rd_addr | input | 4 | register read address |
| rd_data | output | 32 | register read data (combinational) |
| pwm_o | output | 4 | pulse-width outputs of channels 0–3 |
| expired_o | output | 5 | one-cycle expiry pulse per channel |

## Verification
The assertions take two things for granted. The first is that the compare buffer changes the active compare register only through load or reload. The second is that a channel left in `CH_HOLD` sees no tick-driven update. Both hold only if software does not write the count or compare buffers and toggle the load bit within the same cycle. The stimulus always writes one register per write strobe, and it clears the load bit in a later write than the one that set it. Period and duty are measured between consecutive expiry pulses after enough skipped periods to flush the divider's free-running phase. Results therefore do not depend on where the prescaler and divider counters happened to sit when a setting changed.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_LOAD,
        CH_HOLD,
        CH_RUN
    } ch_state_e;

    // Low-bit mask whose all-ones value marks the divider wrap for /2,/4,/8,/16
    function automatic logic [3:0] div_mask(input logic [1:0] sel);
        return (4'd2 << sel) - 4'd1;
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] pre_i,
    output logic             pulse_o
);
    logic [PRE_W-1:0] cnt_q;

    assign pulse_o = (cnt_q >= pre_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (pulse_o) cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pwm_divider.sv
module pwm_divider
    import pwm_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pre_pulse_i,
    input  logic [1:0] sel_i,
    output logic       tick_o
);
    logic [3:0] dcnt_q;

    assign tick_o = pre_pulse_i && ((dcnt_q | ~div_mask(sel_i)) == 4'hF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           dcnt_q <= '0;
        else if (pre_pulse_i) dcnt_q <= dcnt_q + 4'd1;
    end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             load_i,
    input  logic             reload_i,
    input  logic             invert_i,
    input  logic [CNT_W-1:0] cnt_buf_i,
    input  logic [CNT_W-1:0] cmp_buf_i,
    output logic             pwm_o,
    output logic             expired_o
);
    ch_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cmp_q;
    logic             out_q, exp_q;
    logic             step, zero_hit;

    assign step     = (state_q == CH_RUN) && run_i && !load_i && tick_i;
    assign zero_hit = step && (cnt_q == '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d = CH_LOAD;
        end else begin
            unique case (state_q)
                CH_IDLE: state_d = CH_IDLE;
                CH_LOAD: state_d = run_i ? CH_RUN : CH_HOLD;
                CH_HOLD: if (run_i) state_d = CH_RUN;
                CH_RUN: begin
                    if (!run_i)                    state_d = CH_HOLD;
                    else if (zero_hit && !reload_i) state_d = CH_IDLE;
                end
            endcase
        end
    end

    // Counter, compare and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cmp_q <= '0;
            out_q <= 1'b0;
            exp_q <= 1'b0;
        end else begin
            exp_q <= zero_hit;
            if (load_i) begin
                cnt_q <= cnt_buf_i;
                cmp_q <= cmp_buf_i;
                out_q <= 1'b0;
            end else if (step) begin
                if (cnt_q == '0) begin
                    if (reload_i) begin
                        cnt_q <= cnt_buf_i;
                        cmp_q <= cmp_buf_i;
                    end
                    out_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                    if ((cnt_q - 1'b1) == cmp_q) out_q <= 1'b1;
                end
            end
        end
    end

    assign pwm_o     = out_q ^ invert_i;
    assign expired_o = exp_q;

    AST_EXPIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        exp_q |=> !exp_q); // R13
    AST_NO_EARLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_RUN && cnt_q > cmp_q) |-> !out_q); // R6
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_HOLD && !load_i) |=> $stable(cnt_q) && $stable(out_q)); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_IDLE) |-> !out_q); // R10
    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == $past(cnt_buf_i)) && !exp_q); // R8
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int NUM_CH  = 5,
    parameter int PWM_CH  = 4,
    parameter int GRP0_CH = 2,
    parameter int PRE_W   = 8,
    parameter int DIV_W   = 4,
    parameter int CNT_W   = 16,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [PWM_CH-1:0] pwm_o,
    output logic [NUM_CH-1:0] expired_o
);
    localparam int CTL_W   = 4;
    localparam int CTRL_W  = CTL_W * NUM_CH;
    localparam int DIVF_W  = DIV_W * NUM_CH;
    localparam int PRES_W  = 2 * PRE_W;
    localparam int A_PRE   = 0;
    localparam int A_DIV   = 1;
    localparam int A_CTRL  = 2;
    localparam int A_CNT0  = 3;
    localparam int A_CMP0  = A_CNT0 + NUM_CH;

    logic [PRES_W-1:0] pre_q;
    logic [DIVF_W-1:0] div_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  cntb_q [NUM_CH];
    logic [CNT_W-1:0]  cmpb_q [PWM_CH];
    logic [1:0]        pre_pulse;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= '0;
            div_q  <= '0;
            ctrl_q <= '0;
            for (int i = 0; i < NUM_CH; i++) cntb_q[i] <= '0;
            for (int i = 0; i < PWM_CH; i++) cmpb_q[i] <= '0;
        end else if (wr_en) begin
            if (int'(wr_addr) == A_PRE)  pre_q  <= wr_data[PRES_W-1:0];
            if (int'(wr_addr) == A_DIV)  div_q  <= wr_data[DIVF_W-1:0];
            if (int'(wr_addr) == A_CTRL) ctrl_q <= wr_data[CTRL_W-1:0];
            for (int i = 0; i < NUM_CH; i++)
                if (int'(wr_addr) == A_CNT0 + i) cntb_q[i] <= wr_data[CNT_W-1:0];
            for (int i = 0; i < PWM_CH; i++)
                if (int'(wr_addr) == A_CMP0 + i) cmpb_q[i] <= wr_data[CNT_W-1:0];
        end
    end

    always_comb begin
        rd_data = '0;
        if (int'(rd_addr) == A_PRE)  rd_data = DATA_W'(pre_q);
        if (int'(rd_addr) == A_DIV)  rd_data = DATA_W'(div_q);
        if (int'(rd_addr) == A_CTRL) rd_data = DATA_W'(ctrl_q);
        for (int i = 0; i < NUM_CH; i++)
            if (int'(rd_addr) == A_CNT0 + i) rd_data = DATA_W'(cntb_q[i]);
        for (int i = 0; i < PWM_CH; i++)
            if (int'(rd_addr) == A_CMP0 + i) rd_data = DATA_W'(cmpb_q[i]);
    end

    for (genvar g = 0; g < 2; g++) begin : g_pre
        pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
            .clk     (clk),
            .rst_n   (rst_n),
            .pre_i   (pre_q[g*PRE_W +: PRE_W]),
            .pulse_o (pre_pulse[g])
        );
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int GRP = (i < GRP0_CH) ? 0 : 1;
        logic             tick;
        logic             pwm_raw;
        logic [CNT_W-1:0] cmp_src;

        pwm_divider u_div (
            .clk         (clk),
            .rst_n       (rst_n),
            .pre_pulse_i (pre_pulse[GRP]),
            .sel_i       (div_q[i*DIV_W +: 2]),
            .tick_o      (tick)
        );

        if (i < PWM_CH) begin : g_cmp
            assign cmp_src  = cmpb_q[i];
            assign pwm_o[i] = pwm_raw;
        end else begin : g_count_only
            assign cmp_src = '0;
        end

        pwm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_i    (tick),
            .run_i     (ctrl_q[i*CTL_W + 0]),
            .load_i    (ctrl_q[i*CTL_W + 1]),
            .reload_i  (ctrl_q[i*CTL_W + 2]),
            .invert_i  (ctrl_q[i*CTL_W + 3]),
            .cnt_buf_i (cntb_q[i]),
            .cmp_buf_i (cmp_src),
            .pwm_o     (pwm_raw),
            .expired_o (expired_o[i])
        );
    end
endmodule

// File: tb/pwm_timer_test.sv
`timescale 1ns/1ps
module pwm_timer_test;
    localparam int RUN = 1, LOAD = 2, RLD = 4, INV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [3:0]  pwm_o;
    logic [4:0]  expired_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] sh_div  = '0;
    logic [31:0] sh_ctrl = '0;

    typedef struct {
        int    period;
        int    high;
        string req;
    } item_t;
    item_t exp_q[$];

    bit mon_on   = 1'b0;
    int mon_ch   = 0;
    int mon_skip = 0;
    int mon_cyc  = 0;
    int mon_hi   = 0;

    always #4 clk = ~clk;

    pwm_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pwm_o(pwm_o), .expired_o(expired_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a[3:0]; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a[3:0];
        #1 d = rd_data;
    endtask

    task automatic set_ctrl(input int ch, input int nib);
        sh_ctrl[ch*4 +: 4] = nib[3:0];
        wr(2, sh_ctrl);
    endtask

    task automatic set_div(input int ch, input int f);
        sh_div[ch*4 +: 4] = f[3:0];
        wr(1, sh_div);
    endtask

    task automatic wait_exp(input int ch, output int cycles);
        cycles = 0;
        do begin
            @(negedge clk);
            cycles++;
        end while (!expired_o[ch] && cycles < 5000);
    endtask

    // Driver side of the scoreboard: queue expected period/high-time items
    task automatic mon_start(input int ch, input int skip);
        mon_ch = ch; mon_skip = skip; mon_cyc = 0; mon_hi = 0; mon_on = 1'b1;
    endtask

    task automatic push(input int period, input int high, input string req);
        item_t it;
        it.period = period; it.high = high; it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic drain();
        int t;
        t = 0;
        while (exp_q.size() > 0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        check(exp_q.size() == 0, "scoreboard drain", exp_q.size(), 0);
        exp_q.delete();
        mon_on = 1'b0;
    endtask

    // Monitor: measure each period between expiries and the active time within it
    always @(negedge clk) begin
        if (mon_on) begin
            mon_cyc++;
            if (mon_ch < 4 && pwm_o[mon_ch]) mon_hi++;
            if (expired_o[mon_ch]) begin
                if (mon_skip > 0) begin
                    mon_skip--;
                end else if (exp_q.size() > 0) begin
                    item_t it;
                    it = exp_q.pop_front();
                    check(mon_cyc == it.period, {it.req, " period"}, mon_cyc, it.period);
                    check(mon_hi == it.high, {it.req, " active cycles"}, mon_hi, it.high);
                end
                mon_cyc = 0;
                mon_hi  = 0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int c, e, chg;
        logic p0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check(pwm_o == 4'b0, "R1 pwm", int'(pwm_o), 0);
        check(expired_o == 5'b0, "R1 expired", int'(expired_o), 0);
        rd(2, d); check(d == 0, "R1 ctrl", int'(d), 0);
        rd(7, d); check(d == 0, "R1 count buffer", int'(d), 0);

        // R2: register readback
        wr(7, 32'h1234BEEF);
        rd(7, d); check(d == 32'h0000BEEF, "R2 count buffer width", int'(d), 32'hBEEF);
        wr(11, 32'h0000A5A5);
        rd(11, d); check(d == 32'h0000A5A5, "R2 compare buffer", int'(d), 32'hA5A5);
        wr(0, 32'hFFFF0100);
        rd(0, d); check(d == 32'h00000100, "R2 prescaler", int'(d), 32'h100);
        rd(12, d); check(d == 0, "R2 unmapped", int'(d), 0);

        // R8: load held with run set -> no counting
        wr(3, 9); wr(8, 3);
        set_ctrl(0, LOAD | RLD | RUN);
        e = 0;
        repeat (40) begin @(negedge clk); if (expired_o[0]) e++; end
        check(e == 0, "R8 no expiry while loading", e, 0);
        set_ctrl(0, RUN | RLD);

        // R4/R5: N=9, C=3, T=2 -> period 20, active 8
        mon_start(0, 1);
        push(20, 8, "R4"); push(20, 8, "R5"); push(20, 8, "R5");
        drain();

        // R6: C == N never active
        wr(8, 9);
        mon_start(0, 1);
        push(20, 0, "R6"); push(20, 0, "R6");
        drain();

        // R5: C = 0 -> one tick active
        wr(8, 0);
        mon_start(0, 1);
        push(20, 2, "R5 zero compare"); push(20, 2, "R5 zero compare");
        drain();

        // R3: prescaler A=2, divider /4 -> T=12; N=4, C=1 -> 60 / 24
        wr(0, 32'h00000102);
        set_div(0, 1);
        wr(3, 4); wr(8, 1);
        mon_start(0, 2);
        push(60, 24, "R3"); push(60, 24, "R3");
        drain();

        // R7: invert
        set_ctrl(0, RUN | RLD | INV);
        mon_start(0, 1);
        push(60, 36, "R7"); push(60, 36, "R7");
        drain();

        // R3: channel 2 on prescaler B=1, field 4'b0110 -> /8, T=16; N=2, C=1 -> 48 / 32
        set_div(2, 6);
        wr(5, 2); wr(10, 1);
        set_ctrl(2, LOAD | RLD);
        set_ctrl(2, RUN | RLD);
        mon_start(2, 2);
        push(48, 32, "R3 group B"); push(48, 32, "R3 group B");
        drain();

        // R12: channel 4 count-only, B=1, /2 -> T=4; N=3 -> 16
        wr(7, 3);
        set_ctrl(4, LOAD | RLD);
        set_ctrl(4, RUN | RLD);
        mon_start(4, 2);
        push(16, 0, "R12"); push(16, 0, "R12");
        drain();

        // R9: back to T=2, N=9, C=3 on channel 0
        wr(0, 32'h00000100);
        set_div(0, 0);
        wr(3, 9); wr(8, 3);
        set_ctrl(0, RUN | RLD);
        repeat (3) wait_exp(0, c);
        wait_exp(0, c);
        @(negedge clk);
        check(expired_o[0] == 1'b0, "R13 single-cycle pulse", int'(expired_o[0]), 0);
        wr(3, 4);
        wait_exp(0, c);
        check(c + 3 == 20, "R9 current period kept", c + 3, 20);
        wait_exp(0, c);
        check(c == 10, "R9 new period applied", c, 10);

        // R11: halt and resume
        set_ctrl(0, RLD);
        repeat (2) @(negedge clk);
        p0 = pwm_o[0];
        e = 0; chg = 0;
        repeat (60) begin
            @(negedge clk);
            if (expired_o[0]) e++;
            if (pwm_o[0] != p0) chg++;
        end
        check(e == 0, "R11 halted no expiry", e, 0);
        check(chg == 0, "R11 halted output stable", chg, 0);
        set_ctrl(0, RUN | RLD);
        wait_exp(0, c);
        check(c <= 10, "R11 resumes from frozen count", c, 10);

        // R10: one-shot on channel 1 with invert, N=5, C=2, T=2
        wr(4, 5); wr(9, 2);
        set_ctrl(1, LOAD | RUN | INV);
        e = 0;
        repeat (40) begin @(negedge clk); if (expired_o[1]) e++; end
        check(e == 0, "R8 channel 1 loading", e, 0);
        set_ctrl(1, RUN | INV);
        e = 0;
        repeat (80) begin @(negedge clk); if (expired_o[1]) e++; end
        check(e == 1, "R10 single expiry", e, 1);
        check(pwm_o[1] == 1'b1, "R10 inactive level after stop", int'(pwm_o[1]), 1);

        finish_run();
    end
endmodule